// File: doc/BRIEF.md
# Serial Display Driver Sequencer

This block sits on the host side of a serial high-voltage display driver with 60 output stages. It takes one display frame at a time through a valid/ready handshake, turns it into a serial bit stream with its own shift clock, and then fires the latch strobe so that the driver copies the whole frame to its outputs at once. It also drives the driver's two output control pins. The enable pin blanks all outputs when low. The test pin forces every output on when it is high together with enable.

The driver's registers power up in an unknown state. After reset the block therefore runs a purge before anything else. It keeps the output enable low, raises the strobe, and gives one shift clock pulse while the strobe is high. This clears both driver register banks. Output enable stays low until the first real frame has been shifted in and latched. After that, a two-bit mode request picks normal display, blanking or lamp test.

All pin timing is counted in system clock cycles. The counts come from nanosecond parameters and are rounded up, so the shift clock, data setup and hold, strobe spacing and strobe width always meet the driver's minimums.

Top module: `hvdrv_sequencer`

## Requirements
- R1: From reset until the first frame has been latched, `drv_enable` and `drv_test` are low whatever the mode request is, and `frame_ready` is low while the purge runs.
- R2: After reset the block raises `strobe` and then gives at least one rising `sclk` edge while `strobe` is still high, with `sdata` at 0. It then lowers `strobe` and raises `frame_ready`.
- R3: A frame is taken only when `frame_valid` and `frame_ready` are both high. A `frame_valid` raised during a transfer starts nothing and does not change the frame being sent.
- R4: Each frame gives exactly FRAME_BITS rising `sclk` edges. Bit FRAME_BITS-1 is sent first and bit 0 last, so driver stage k (counting from 1, where the newest bit lands) holds frame bit k-1 after the strobe.
- R5: Every high phase of `sclk` lasts at least HALF_CNT = ceil(max(HALF_NS,80) * SYS_CLK_MHZ / 1000) cycles. Every low phase lasts at least that many cycles too. With the defaults this is 32 cycles.
- R6: `sdata` changes only while `sclk` is low. It is stable for at least SETUP_CNT = ceil(SETUP_NS * SYS_CLK_MHZ / 1000) cycles (13 by default) before each rising edge, and for at least that many cycles after it.
- R7: In a transfer, `strobe` rises at least SETUP_CNT cycles after the last `sclk` fall. It stays high for at least STB_CNT = ceil(max(STROBE_NS,80) * SYS_CLK_MHZ / 1000) cycles (20 by default), and `sclk` stays low the whole time.
- R8: `busy` is high from the cycle after a frame is accepted until the strobe falls. `done` is a single-cycle pulse in the cycle right after the strobe falls. `frame_ready` returns the cycle after `done`.
- R9: The mode request is registered with one cycle of latency once a frame has been latched. The codes are: 2'b00 normal (`drv_enable`=1, `drv_test`=0), 2'b01 blank (0,0), 2'b10 lamp test (1,1), and 2'b11 blank (0,0).
- R10: A mode change takes effect one cycle later in any phase of a transfer, including while the strobe is high, and it does not disturb the frame being latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | Frame offered |
| frame_data | input | FRAME_BITS | Frame; bit 0 ends in driver stage 1 |
| frame_ready | output | 1 | Block is idle and will take a frame |
| mode_req | input | 2 | Output mode request (see R9) |
| sdata | output | 1 | Serial data to the driver |
| sclk | output | 1 | Shift clock to the driver |
| strobe | output | 1 | Latch strobe to the driver |
| drv_enable | output | 1 | Output enable pin; low blanks the driver |
| drv_test | output | 1 | All-on test pin |
| busy | output | 1 | Shift and strobe phases in progress |
| done | output | 1 | One-cycle pulse after a frame is latched |

## Verification
Two functions can fall in the same cycle: a mode request reaching the control pins, and the strobe latching a frame. The bench waits until it sees the strobe high and then switches the mode to lamp test on that same edge. On the next cycle it requires the test and enable pins to show the new mode while the strobe is still high. When `done` comes, it requires the modelled driver latch to hold exactly the frame that was sent. A second overlap is a `frame_valid` raised in the middle of a shift. This is judged by checking that the latched frame and the count of shift clock edges stay unchanged.

// File: rtl/hvseq_pkg.sv
package hvseq_pkg;

  typedef enum logic [3:0] {
    ST_ARM,
    ST_PG_SETUP,
    ST_PG_CLK_HI,
    ST_PG_CLK_LO,
    ST_IDLE,
    ST_SH_LO,
    ST_SH_HI,
    ST_GAP,
    ST_STROBE,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_NORMAL    = 2'b00,
    MODE_BLANK     = 2'b01,
    MODE_LAMP      = 2'b10,
    MODE_BLANK_ALT = 2'b11
  } drv_mode_e;

  typedef struct packed {
    logic sclk;
    logic strobe;
    logic ready;
    logic busy;
    logic done;
  } seq_pins_t;

  // Round a nanosecond interval up to whole system clock cycles.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels that belong to each sequencer state.
  function automatic seq_pins_t decode_state(input seq_state_e s);
    seq_pins_t p;
    p = '0;
    case (s)
      ST_PG_SETUP:  p.strobe = 1'b1;
      ST_PG_CLK_HI: begin p.strobe = 1'b1; p.sclk = 1'b1; end
      ST_PG_CLK_LO: p.strobe = 1'b1;
      ST_IDLE:      p.ready = 1'b1;
      ST_SH_LO:     p.busy = 1'b1;
      ST_SH_HI:     begin p.busy = 1'b1; p.sclk = 1'b1; end
      ST_GAP:       p.busy = 1'b1;
      ST_STROBE:    begin p.busy = 1'b1; p.strobe = 1'b1; end
      ST_DONE:      p.done = 1'b1;
      default:      p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/hvseq_timer.sv
module hvseq_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/hvseq_shifter.sv
module hvseq_shifter #(
  parameter int N = 60
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [N-1:0] frame,
  output logic         ser_bit,
  output logic         last_bit
);
  localparam int BIT_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     sr_q;
  logic [BIT_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sr_q  <= frame;
      idx_q <= '0;
    end else if (shift) begin
      sr_q  <= {sr_q[N-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  // The top bit goes out first, so bit 0 is the last one clocked in.
  assign ser_bit  = sr_q[N-1];
  assign last_bit = (idx_q == BIT_W'(N - 1));
endmodule

// File: rtl/hvseq_pins.sv
module hvseq_pins
  import hvseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loaded,
  input  logic [1:0] mode_req,
  output logic       drv_enable,
  output logic       drv_test
);
  drv_mode_e mode;
  assign mode = drv_mode_e'(mode_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_enable <= 1'b0;
      drv_test   <= 1'b0;
    end else begin
      drv_enable <= loaded && (mode == MODE_NORMAL || mode == MODE_LAMP);
      drv_test   <= loaded && (mode == MODE_LAMP);
    end
  end
endmodule

// File: rtl/hvdrv_sequencer.sv
module hvdrv_sequencer
  import hvseq_pkg::*;
#(
  parameter int FRAME_BITS  = 60,
  parameter int SYS_CLK_MHZ = 250,
  parameter int HALF_NS     = 125,
  parameter int SETUP_NS    = 50,
  parameter int STROBE_NS   = 80
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_valid,
  input  logic [FRAME_BITS-1:0] frame_data,
  output logic                  frame_ready,
  input  logic [1:0]            mode_req,
  output logic                  sdata,
  output logic                  sclk,
  output logic                  strobe,
  output logic                  drv_enable,
  output logic                  drv_test,
  output logic                  busy,
  output logic                  done
);
  localparam int unsigned HALF_CNT  = ns_to_cycles(max2(HALF_NS, 80), SYS_CLK_MHZ);
  localparam int unsigned SETUP_CNT = max2(ns_to_cycles(SETUP_NS, SYS_CLK_MHZ), 1);
  localparam int unsigned STB_CNT   = ns_to_cycles(max2(STROBE_NS, 80), SYS_CLK_MHZ);
  localparam int unsigned LOW_CNT   = max2(HALF_CNT, SETUP_CNT);
  localparam int unsigned MAX_CNT   = max2(max2(LOW_CNT, HALF_CNT), max2(SETUP_CNT, STB_CNT));
  localparam int          CNT_W     = $clog2(MAX_CNT + 1);

  localparam logic [CNT_W-1:0] LD_HALF  = CNT_W'(HALF_CNT - 1);
  localparam logic [CNT_W-1:0] LD_LOW   = CNT_W'(LOW_CNT - 1);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CNT - 1);
  localparam logic [CNT_W-1:0] LD_STB   = CNT_W'(STB_CNT - 1);

  seq_state_e       state_q, state_n;
  seq_pins_t        pins_q;
  logic             loaded_q;
  logic             tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_last, ser_bit;

  hvseq_timer #(.W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  hvseq_shifter #(.N(FRAME_BITS)) shifter_i (
    .clk      (clk),
    .rst      (rst),
    .load     (sh_load),
    .shift    (sh_shift),
    .frame    (frame_data),
    .ser_bit  (ser_bit),
    .last_bit (sh_last)
  );

  hvseq_pins pins_i (
    .clk        (clk),
    .rst        (rst),
    .loaded     (loaded_q),
    .mode_req   (mode_req),
    .drv_enable (drv_enable),
    .drv_test   (drv_test)
  );

  always_comb begin
    state_n  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    case (state_q)
      ST_ARM: begin
        state_n  = ST_PG_SETUP;
        tmr_load = 1'b1;
        tmr_val  = LD_LOW;
      end
      ST_PG_SETUP: if (tmr_last) begin
        state_n  = ST_PG_CLK_HI;
        tmr_load = 1'b1;
        tmr_val  = LD_HALF;
      end
      ST_PG_CLK_HI: if (tmr_last) begin
        state_n  = ST_PG_CLK_LO;
        tmr_load = 1'b1;
        tmr_val  = LD_SETUP;
      end
      ST_PG_CLK_LO: if (tmr_last) state_n = ST_IDLE;
      ST_IDLE: if (frame_valid && pins_q.ready) begin
        state_n  = ST_SH_LO;
        tmr_load = 1'b1;
        tmr_val  = LD_LOW;
        sh_load  = 1'b1;
      end
      ST_SH_LO: if (tmr_last) begin
        state_n  = ST_SH_HI;
        tmr_load = 1'b1;
        tmr_val  = LD_HALF;
      end
      ST_SH_HI: if (tmr_last) begin
        tmr_load = 1'b1;
        if (sh_last) begin
          state_n = ST_GAP;
          tmr_val = LD_SETUP;
        end else begin
          state_n  = ST_SH_LO;
          tmr_val  = LD_LOW;
          sh_shift = 1'b1;
        end
      end
      ST_GAP: if (tmr_last) begin
        state_n  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = LD_STB;
      end
      ST_STROBE: if (tmr_last) state_n = ST_DONE;
      ST_DONE:   state_n = ST_IDLE;
      default:   state_n = ST_ARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_ARM;
      pins_q   <= decode_state(ST_ARM);
      loaded_q <= 1'b0;
    end else begin
      state_q <= state_n;
      pins_q  <= decode_state(state_n);
      if (state_n == ST_DONE) loaded_q <= 1'b1;
    end
  end

  assign sdata       = ser_bit;
  assign sclk        = pins_q.sclk;
  assign strobe      = pins_q.strobe;
  assign frame_ready = pins_q.ready;
  assign busy        = pins_q.busy;
  assign done        = pins_q.done;
endmodule

// File: rtl/hvdrv_sequencer_chk.sv
module hvdrv_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic sdata,
  input logic sclk,
  input logic strobe,
  input logic frame_ready,
  input logic busy,
  input logic done,
  input logic drv_enable,
  input logic drv_test
);
  logic seen_done;

  always_ff @(posedge clk) begin
    if (rst)       seen_done <= 1'b0;
    else if (done) seen_done <= 1'b1;
  end

  // R1: pins stay blank until a frame has been latched
  a_r1_blank_until_latched: assert property (@(posedge clk) disable iff (rst)
    !seen_done |-> (!drv_enable && !drv_test));

  // R2: a shift clock edge outside a transfer only happens during the purge, with the strobe high
  a_r2_purge_edge_with_strobe: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && !busy) |-> strobe);

  // R3: never ready while a transfer is running
  a_r3_ready_excludes_busy: assert property (@(posedge clk) disable iff (rst)
    !(frame_ready && busy));

  // R6: data holds still while the shift clock is high
  a_r6_data_stable_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdata));

  // R7: no shift clock while the transfer strobe is high
  a_r7_no_clock_in_strobe: assert property (@(posedge clk) disable iff (rst)
    (busy && strobe) |-> !sclk);

  // R8: done follows the strobe and lasts one cycle
  a_r8_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(strobe) && !strobe && !busy));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: the test pin never goes high without the enable pin
  a_r9_test_needs_enable: assert property (@(posedge clk) disable iff (rst)
    drv_test |-> drv_enable);
endmodule

bind hvdrv_sequencer hvdrv_sequencer_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .sdata       (sdata),
  .sclk        (sclk),
  .strobe      (strobe),
  .frame_ready (frame_ready),
  .busy        (busy),
  .done        (done),
  .drv_enable  (drv_enable),
  .drv_test    (drv_test)
);

// File: tb/hvdrv_sequencer_tb_top.sv
`timescale 1ns/1ps
module hvdrv_sequencer_tb_top;
  localparam int N     = 60;
  localparam int HALF  = 32;
  localparam int SETUP = 13;
  localparam int STB   = 20;

  typedef struct packed {
    logic [N-1:0] frame;
    logic [1:0]   mode;
    logic         en;
    logic         test;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{60'hAAAAAAAAAAAAAAA, 2'b00, 1'b1, 1'b0},
    '{60'h555555555555555, 2'b10, 1'b1, 1'b1},
    '{60'h000000000000001, 2'b01, 1'b0, 1'b0},
    '{60'h800000000000000, 2'b11, 1'b0, 1'b0},
    '{60'h0F1E2D3C4B5A697, 2'b00, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_valid = 1'b0;
  logic [N-1:0] frame_data = '0;
  logic [1:0] mode_req = 2'b00;
  logic frame_ready, sdata, sclk, strobe, drv_enable, drv_test, busy, done;

  always #2 clk = ~clk;

  hvdrv_sequencer dut_i (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid),
    .frame_data  (frame_data),
    .frame_ready (frame_ready),
    .mode_req    (mode_req),
    .sdata       (sdata),
    .sclk        (sclk),
    .strobe      (strobe),
    .drv_enable  (drv_enable),
    .drv_test    (drv_test),
    .busy        (busy),
    .done        (done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural model of the driver and pin timing monitor, sampled on negedges.
  logic [N-1:0] m_sr  = '1;
  logic [N-1:0] m_lat = '1;
  logic p_sclk = 1'b0, p_stb = 1'b0, p_sd = 1'b0;
  int purge_clears = 0, rises = 0, done_cnt = 0, sd_hi_changes = 0;
  int since_rise = 1000000, since_fall = 1000000, sd_age = 1000000;
  int hi_run = 0, lo_run = 0, stb_run = 0;
  int min_hi = 1000000, min_lo = 1000000, min_setup = 1000000, min_hold = 1000000;
  int min_gap = 1000000, min_stb = 1000000;

  always @(negedge clk) begin
    if (!rst) begin
      since_rise++; since_fall++; sd_age++;
      if (sdata !== p_sd) begin
        if (since_rise < min_hold) min_hold = since_rise;
        if (sclk) sd_hi_changes++;
        sd_age = 0;
      end
      if (sclk && !p_sclk) begin
        if (strobe) begin
          m_sr = '0; m_lat = '0; purge_clears++;
        end else begin
          m_sr = {m_sr[N-2:0], sdata};
        end
        rises++;
        if (sd_age < min_setup) min_setup = sd_age;
        if (lo_run < min_lo) min_lo = lo_run;
        since_rise = 0;
        lo_run = 0;
      end
      if (!sclk && p_sclk) begin
        if (hi_run < min_hi) min_hi = hi_run;
        since_fall = 0;
        hi_run = 0;
      end
      if (sclk) hi_run++; else lo_run++;
      if (strobe && !p_stb) begin
        m_lat = m_sr;
        if (since_fall < min_gap) min_gap = since_fall;
      end
      if (!strobe && p_stb) begin
        if (stb_run < min_stb) min_stb = stb_run;
        stb_run = 0;
      end
      if (strobe) stb_run++;
      if (done) done_cnt++;
      p_sclk = sclk; p_stb = strobe; p_sd = sdata;
    end
  end

  task automatic wait_ready();
    while (!frame_ready) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic send(input logic [N-1:0] f);
    wait_ready();
    frame_valid = 1'b1;
    frame_data  = f;
    @(negedge clk);
    frame_valid = 1'b0;
    check(busy === 1'b1 && frame_ready === 1'b0, "R8 busy after accept", {busy, frame_ready}, 2'b10);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    summary();
  end

  initial begin
    int base;
    logic [N-1:0] fa, fb, fc;
    repeat (5) @(negedge clk);
    // R1: outputs during reset
    check({drv_enable, drv_test, frame_ready, busy, done, sclk} === 6'b0, "R1 reset state",
          {drv_enable, drv_test, frame_ready, busy, done, sclk}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(frame_ready === 1'b0 && drv_enable === 1'b0, "R1 purge in progress", {frame_ready, drv_enable}, 0);
    wait_ready();
    // R2: purge cleared the driver, strobe back low, data line low
    check(purge_clears >= 1, "R2 clock edge under strobe", purge_clears, 1);
    check(m_lat === '0 && strobe === 1'b0 && sdata === 1'b0, "R2 driver cleared", m_lat, 0);
    repeat (20) @(negedge clk);
    check(drv_enable === 1'b0 && drv_test === 1'b0, "R1 blank before first frame", {drv_enable, drv_test}, 0);

    for (int i = 0; i < NV; i++) begin
      base = rises;
      send(VECS[i].frame);
      wait_done();
      check(strobe === 1'b0 && busy === 1'b0, "R8 done after strobe", {strobe, busy}, 0);
      check(m_lat === VECS[i].frame, "R4 latched frame", m_lat, VECS[i].frame);
      check(rises - base == N, "R4 edge count", rises - base, N);
      mode_req = VECS[i].mode;
      @(negedge clk);
      check(done === 1'b0 && frame_ready === 1'b1, "R8 done single and ready back", {done, frame_ready}, 2'b01);
      check({drv_enable, drv_test} === {VECS[i].en, VECS[i].test}, "R9 mode pins",
            {drv_enable, drv_test}, {VECS[i].en, VECS[i].test});
    end

    // R3: valid raised mid-transfer is ignored
    mode_req = 2'b00;
    fa = 60'h123456789ABCDEF;
    fb = 60'hFEDCBA987654321;
    base = rises;
    send(fa);
    repeat (100) @(negedge clk);
    frame_valid = 1'b1;
    frame_data  = fb;
    repeat (50) @(negedge clk);
    frame_valid = 1'b0;
    wait_done();
    check(m_lat === fa, "R3 frame unchanged", m_lat, fa);
    repeat (300) @(negedge clk);
    check(busy === 1'b0 && rises - base == N && m_lat === fa, "R3 no second transfer", rises - base, N);

    // R10: mode change in the strobe cycle
    fc = 60'hC3C3C3C3C3C3C3C;
    send(fc);
    while (!strobe) @(negedge clk);
    mode_req = 2'b10;
    @(negedge clk);
    check(strobe === 1'b1 && drv_test === 1'b1 && drv_enable === 1'b1, "R10 mode during strobe",
          {strobe, drv_enable, drv_test}, 3'b111);
    wait_done();
    check(m_lat === fc, "R10 frame intact", m_lat, fc);
    mode_req = 2'b01;
    @(negedge clk);
    check({drv_enable, drv_test} === 2'b00, "R9 blank", {drv_enable, drv_test}, 0);

    // Timing over the whole run
    check(min_hi >= HALF, "R5 high phase", min_hi, HALF);
    check(min_lo >= HALF, "R5 low phase", min_lo, HALF);
    check(min_setup >= SETUP, "R6 setup", min_setup, SETUP);
    check(min_hold >= SETUP && sd_hi_changes == 0, "R6 hold", min_hold, SETUP);
    check(min_gap >= SETUP, "R7 strobe gap", min_gap, SETUP);
    check(min_stb >= STB, "R7 strobe width", min_stb, STB);
    check(done_cnt == NV + 2, "R8 done count", done_cnt, NV + 2);
    summary();
  end
endmodule